// File: doc/BRIEF.md
# 10BASE-T Transmit Jabber and Heartbeat Supervisor

This block watches the MII transmit enable of a 10BASE-T port and does two things. It times each transmission, and if the transmit enable stays high too long it enters a jabber lockout. In lockout the transmit gate is forced off and a jabber status is raised. The lockout ends only after transmit enable has stayed low for a long, unbroken idle interval.

The block also produces the SQE heartbeat. When a transmission ends, it waits a short delay and then drives a pulse of fixed width on the collision output. No pulse is sent after a transmission that saw a collision, while repeater mode is set, while the disable control is set, or outside 10BASE-T mode. If transmit enable rises again during the delay or the pulse, the pending pulse is dropped. The collision output also carries the live collision indication.

All durations are clock-cycle counts given as parameters. At the default 125 MHz clock the defaults give a 20 ms jabber limit, a 500 ms release interval, and a 1 µs delay and 1 µs pulse.

Top module: `tx_jabber_sqe_sup`

## Requirements
- R1: In 10BASE-T mode, `jabber_o` rises at the rising clock edge that samples `tx_en_i` high for the JAB_LIMIT-th consecutive time. Fewer consecutive high samples leave it low.
- R2: While `jabber_o` is 1, `tx_gate_o` is 0. While `jabber_o` is 0, `tx_gate_o` equals `tx_en_i`.
- R3: Once in jabber, `jabber_o` falls at the edge that samples `tx_en_i` low for the UNJAB_IDLE-th consecutive time.
- R4: Let E0 be the edge that samples `tx_en_i` low right after a high sample, with the heartbeat allowed. Then `col_o` is 0 until edge E0+SQE_DELAY, and 1 for the SQE_WIDTH clock periods that follow that edge.
- R5: A transmission during which `col_det_i` was sampled high while `tx_en_i` was high produces no heartbeat. This collision memory is cleared when the next transmission starts.
- R6: While `repeater_i` is 1, `col_o` carries no heartbeat.
- R7: While `sqe_dis_i` is 1, `col_o` carries no heartbeat.
- R8: While `mode_10bt_i` is 0, `col_o` carries no heartbeat and the jabber timer does not advance.
- R9: If `tx_en_i` goes high during the heartbeat delay or pulse, `col_o` drops at once and the pending heartbeat is cancelled.
- R10: A high sample of `tx_en_i` during the jabber release wait restarts the idle count from zero.
- R11: Whenever `col_det_i` is 1, `col_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | MII transmit enable from the MAC |
| col_det_i | input | 1 | Collision detected on the medium |
| repeater_i | input | 1 | Repeater mode; forces the heartbeat off |
| sqe_dis_i | input | 1 | Heartbeat disable control |
| mode_10bt_i | input | 1 | Port operates in 10BASE-T mode |
| tx_gate_o | output | 1 | Transmit enable allowed onto the line |
| jabber_o | output | 1 | Jabber lockout status |
| col_o | output | 1 | Collision output: live collision OR heartbeat |

## Verification
The hardest case to reach is a release wait broken by a single high sample one cycle before the release count would complete. Here the idle count must restart, and the only evidence is that the status stays set for a full interval longer. A directed sequence counts clock periods exactly to land that single high sample, using small limit values. The heartbeat cancellation is reached in the same way, with one directed reassertion placed inside the pulse. Random bursts whose high and low lengths straddle the shrunk thresholds then mix these events with collisions and control changes.

// File: rtl/tjs_pkg.sv
package tjs_pkg;

  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_state_e;

  // Bits needed to hold the values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tjs_tx_track.sv
module tjs_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic col_det_i,
  output logic tx_fall_o,
  output logic coll_seen_o
);

  logic tx_prev_q;
  logic seen_q, seen_d;
  logic tx_rise;

  assign tx_rise   = tx_en_i & ~tx_prev_q;
  assign tx_fall_o = tx_prev_q & ~tx_en_i;

  // Memory of a collision within the current transmission; a new start clears it.
  always_comb begin
    seen_d = tx_rise ? 1'b0 : seen_q;
    if (tx_en_i && col_det_i) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_prev_q <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      tx_prev_q <= tx_en_i;
      seen_q    <= seen_d;
    end
  end

  assign coll_seen_o = seen_q;

endmodule

// File: rtl/tjs_jabber_timer.sv
module tjs_jabber_timer #(
  parameter int unsigned JAB_LIMIT  = 2_500_000,
  parameter int unsigned UNJAB_IDLE = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic mode_10bt_i,
  output logic jabber_o
);

  localparam int unsigned RW = tjs_pkg::cnt_width(JAB_LIMIT);
  localparam int unsigned IW = tjs_pkg::cnt_width(UNJAB_IDLE);
  localparam logic [RW-1:0] RUN_LAST  = RW'(JAB_LIMIT - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(UNJAB_IDLE - 1);

  logic [RW-1:0] run_q, run_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          jab_q, jab_d;
  logic          run_en, idle_en;

  always_comb begin
    jab_d  = jab_q;
    run_d  = run_q;
    idle_d = idle_q;
    if (!jab_q) begin
      idle_d = '0;
      if (tx_en_i && mode_10bt_i) begin
        if (run_q == RUN_LAST) begin
          jab_d = 1'b1;
          run_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end else begin
      run_d = '0;
      if (tx_en_i) begin
        idle_d = '0;
      end else if (idle_q == IDLE_LAST) begin
        jab_d  = 1'b0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  // Each counter is clocked only while it is busy or about to become busy.
  assign run_en  = ~jab_q | (run_q != '0);
  assign idle_en = jab_q | (idle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (idle_en) begin
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab_q <= 1'b0;
    end else begin
      jab_q <= jab_d;
    end
  end

  assign jabber_o = jab_q;

endmodule

// File: rtl/tjs_sqe_gen.sv
module tjs_sqe_gen #(
  parameter int unsigned SQE_DELAY = 125,
  parameter int unsigned SQE_WIDTH = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic tx_fall_i,
  input  logic coll_seen_i,
  input  logic sqe_ok_i,
  output logic pulse_o
);

  import tjs_pkg::*;

  localparam int unsigned SPAN = (SQE_DELAY > SQE_WIDTH) ? SQE_DELAY : SQE_WIDTH;
  localparam int unsigned CW   = cnt_width(SPAN);
  localparam logic [CW-1:0] DLY_LAST = CW'(SQE_DELAY - 1);
  localparam logic [CW-1:0] WID_LAST = CW'(SQE_WIDTH - 1);

  sqe_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SQE_IDLE: begin
        if (tx_fall_i && sqe_ok_i && !coll_seen_i) begin
          st_d  = SQE_WAIT;
          cnt_d = '0;
        end
      end
      SQE_WAIT: begin
        if (tx_en_i || !sqe_ok_i) begin
          st_d  = SQE_IDLE;
          cnt_d = '0;
        end else if (cnt_q == DLY_LAST) begin
          st_d  = SQE_PULSE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQE_PULSE: begin
        if (tx_en_i || !sqe_ok_i || (cnt_q == WID_LAST)) begin
          st_d  = SQE_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = SQE_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign cnt_en = (st_q != SQE_IDLE) | (st_d != SQE_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQE_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (st_q == SQE_PULSE);

endmodule

// File: rtl/tx_jabber_sqe_sup.sv
module tx_jabber_sqe_sup #(
  parameter int unsigned JAB_LIMIT  = 2_500_000,
  parameter int unsigned UNJAB_IDLE = 62_500_000,
  parameter int unsigned SQE_DELAY  = 125,
  parameter int unsigned SQE_WIDTH  = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic col_det_i,
  input  logic repeater_i,
  input  logic sqe_dis_i,
  input  logic mode_10bt_i,
  output logic tx_gate_o,
  output logic jabber_o,
  output logic col_o
);

  logic tx_fall;
  logic coll_seen;
  logic jab;
  logic hb_pulse;
  logic sqe_ok;

  assign sqe_ok = mode_10bt_i & ~repeater_i & ~sqe_dis_i;

  tjs_tx_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en_i),
    .col_det_i   (col_det_i),
    .tx_fall_o   (tx_fall),
    .coll_seen_o (coll_seen)
  );

  tjs_jabber_timer #(
    .JAB_LIMIT  (JAB_LIMIT),
    .UNJAB_IDLE (UNJAB_IDLE)
  ) u_jab (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en_i),
    .mode_10bt_i (mode_10bt_i),
    .jabber_o    (jab)
  );

  tjs_sqe_gen #(
    .SQE_DELAY (SQE_DELAY),
    .SQE_WIDTH (SQE_WIDTH)
  ) u_sqe (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en_i),
    .tx_fall_i   (tx_fall),
    .coll_seen_i (coll_seen),
    .sqe_ok_i    (sqe_ok),
    .pulse_o     (hb_pulse)
  );

  // Blocking and masking act in the same cycle as the input that causes them.
  assign tx_gate_o = tx_en_i & ~jab;
  assign jabber_o  = jab;
  assign col_o     = col_det_i | (hb_pulse & sqe_ok & ~tx_en_i);

endmodule

// File: rtl/tjs_chk.sv
module tjs_chk #(
  parameter int unsigned JAB_LIMIT  = 2_500_000,
  parameter int unsigned UNJAB_IDLE = 62_500_000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en_i,
  input logic col_det_i,
  input logic repeater_i,
  input logic sqe_dis_i,
  input logic mode_10bt_i,
  input logic tx_gate_o,
  input logic jabber_o,
  input logic col_o
);

  logic [31:0] hi_run_q;
  logic [31:0] lo_run_q;

  // Saturating run-length counters of transmit enable, seen from the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      if (tx_en_i && mode_10bt_i) begin
        if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
      end else begin
        hi_run_q <= '0;
      end
      if (!tx_en_i) begin
        if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
      end else begin
        lo_run_q <= '0;
      end
    end
  end

  AST_JAB_AFTER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(jabber_o) |-> (hi_run_q >= JAB_LIMIT)); // R1
  AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) jabber_o |-> !tx_gate_o); // R2
  AST_UNJAB_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(jabber_o) |-> (lo_run_q >= UNJAB_IDLE)); // R3
  AST_NO_HB_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) ($fell(tx_en_i) && !col_det_i) |-> !col_o); // R4
  AST_NO_HB_REPEATER: assert property (@(posedge clk) disable iff (!rst_n) (repeater_i && !col_det_i) |-> !col_o); // R6
  AST_NO_HB_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (sqe_dis_i && !col_det_i) |-> !col_o); // R7
  AST_NO_HB_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n) (!mode_10bt_i && !col_det_i) |-> !col_o); // R8
  AST_NO_JAB_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n) !mode_10bt_i |=> !$rose(jabber_o)); // R8
  AST_NO_HB_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n) (tx_en_i && !col_det_i) |-> !col_o); // R9
  AST_COL_PASSES: assert property (@(posedge clk) disable iff (!rst_n) col_det_i |-> col_o); // R11

endmodule

bind tx_jabber_sqe_sup tjs_chk #(
  .JAB_LIMIT  (JAB_LIMIT),
  .UNJAB_IDLE (UNJAB_IDLE)
) chk_i (.*);

// File: tb/tx_jabber_sqe_sup_tb_top.sv
`timescale 1ns/1ps
module tx_jabber_sqe_sup_tb_top;

  localparam int JAB = 40;
  localparam int UNJ = 60;
  localparam int DLY = 8;
  localparam int WID = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, col_det = 1'b0, rep = 1'b0, dis = 1'b0, mode = 1'b1;
  logic tx_gate, jabber, col;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tx_jabber_sqe_sup #(
    .JAB_LIMIT(JAB), .UNJAB_IDLE(UNJ), .SQE_DELAY(DLY), .SQE_WIDTH(WID)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .col_det_i(col_det),
    .repeater_i(rep), .sqe_dis_i(dis), .mode_10bt_i(mode),
    .tx_gate_o(tx_gate), .jabber_o(jabber), .col_o(col)
  );

  // Reference model written from the requirements.
  int m_run, m_idle, m_cnt, m_ph;
  bit m_jab, m_prev, m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_idle = 0; m_cnt = 0; m_ph = 0;
      m_jab = 0; m_prev = 0; m_seen = 0;
    end else begin
      bit ok;
      ok = mode && !rep && !dis;
      if (!m_jab) begin
        m_idle = 0;
        if (tx_en && mode) begin
          if (m_run == JAB - 1) begin m_jab = 1; m_run = 0; end
          else m_run++;
        end else m_run = 0;
      end else begin
        m_run = 0;
        if (tx_en) m_idle = 0;
        else if (m_idle == UNJ - 1) begin m_jab = 0; m_idle = 0; end
        else m_idle++;
      end
      case (m_ph)
        0: if (m_prev && !tx_en && ok && !m_seen) begin m_ph = 1; m_cnt = 0; end
        1: if (tx_en || !ok) m_ph = 0;
           else if (m_cnt == DLY - 1) begin m_ph = 2; m_cnt = 0; end
           else m_cnt++;
        default: if (tx_en || !ok || m_cnt == WID - 1) m_ph = 0;
                 else m_cnt++;
      endcase
      if (tx_en && !m_prev) m_seen = 0;
      if (tx_en && col_det) m_seen = 1;
      m_prev = tx_en;
    end
  end

  function automatic bit exp_gate(bit t, bit j);
    return t && !j;
  endfunction

  function automatic bit exp_col(bit c, bit t, bit r, bit d, bit m, int ph);
    return c || ((ph == 2) && !t && !r && !d && m);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic c, input logic r, input logic d, input logic m);
    @(posedge clk);
    #2;
    tx_en = t; col_det = c; rep = r; dis = d; mode = m;
    #2;
  endtask

  // Ends a transmission and checks the heartbeat window cycle by cycle.
  task automatic fall_and_watch(input bit expect_hb, input logic r, input logic d,
                                input logic m, input string tag);
    int highs = 0;
    drive(1, 0, r, d, m);
    for (int k = 1; k <= DLY + WID + 3; k++) begin
      bit e;
      drive(0, 0, r, d, m);
      e = expect_hb && (k >= DLY + 2) && (k <= DLY + 1 + WID);
      chk(col, e, tag, $sformatf("col_o at cycle %0d after fall", k));
      if (col === 1'b1) highs++;
    end
    chk(highs == (expect_hb ? WID : 0), 1'b1, tag, "heartbeat width");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(0, 0, 0, 0, 1);
    chk(jabber, 1'b0, "R1", "jabber_o after reset");
    chk(tx_gate, 1'b0, "R2", "tx_gate_o after reset");
    chk(col, 1'b0, "R4", "col_o after reset");

    // R4: plain heartbeat
    repeat (4) drive(1, 0, 0, 0, 1);
    chk(tx_gate, 1'b1, "R2", "tx_gate_o follows tx_en");
    fall_and_watch(1, 0, 0, 1, "R4");

    // R5 and R11: collision during transmission suppresses the heartbeat
    repeat (3) drive(1, 0, 0, 0, 1);
    drive(1, 1, 0, 0, 1);
    chk(col, 1'b1, "R11", "col_o with col_det_i");
    drive(1, 0, 0, 0, 1);
    fall_and_watch(0, 0, 0, 1, "R5");
    // R5: memory cleared by the next start
    repeat (3) drive(1, 0, 0, 0, 1);
    fall_and_watch(1, 0, 0, 1, "R5");

    // R6, R7, R8
    repeat (3) drive(1, 0, 1, 0, 1);
    fall_and_watch(0, 1, 0, 1, "R6");
    repeat (3) drive(1, 0, 0, 1, 1);
    fall_and_watch(0, 0, 1, 1, "R7");
    repeat (JAB + 5) drive(1, 0, 0, 0, 0);
    chk(jabber, 1'b0, "R8", "no jabber outside 10BASE-T mode");
    fall_and_watch(0, 0, 0, 0, "R8");

    // R9: reassertion inside the pulse
    repeat (3) drive(1, 0, 0, 0, 1);
    for (int k = 1; k <= DLY + 3; k++) drive(0, 0, 0, 0, 1);
    chk(col, 1'b1, "R9", "pulse active before reassert");
    drive(1, 0, 0, 0, 1);
    chk(col, 1'b0, "R9", "col_o drops on reassert");
    drive(1, 0, 0, 0, 1);
    chk(col, 1'b0, "R9", "pulse stays cancelled");
    fall_and_watch(1, 0, 0, 1, "R9");

    // R1, R2: jabber trips exactly at the limit
    repeat (JAB) drive(1, 0, 0, 0, 1);
    chk(jabber, 1'b0, "R1", "jabber_o one sample before limit");
    chk(tx_gate, 1'b1, "R2", "tx_gate_o before trip");
    drive(1, 0, 0, 0, 1);
    chk(jabber, 1'b1, "R1", "jabber_o at limit");
    chk(tx_gate, 1'b0, "R2", "tx_gate_o blocked in jabber");

    // R10: one high sample just before release restarts the wait
    repeat (UNJ - 1) drive(0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 1);
    chk(jabber, 1'b1, "R10", "still in jabber before reassert counted");
    chk(tx_gate, 1'b0, "R2", "tx_gate_o blocked during release wait");
    repeat (UNJ) drive(0, 0, 0, 0, 1);
    chk(jabber, 1'b1, "R10", "idle count restarted");
    drive(0, 0, 0, 0, 1);
    chk(jabber, 1'b0, "R3", "release after full idle interval");
    drive(1, 0, 0, 0, 1);
    chk(tx_gate, 1'b1, "R2", "tx_gate_o passes after release");
    repeat (DLY + WID + 4) drive(0, 0, 0, 0, 1);

    // Random bursts against the reference model
    for (int b = 0; b < 40; b++) begin
      logic r, d, m;
      int hi_len, lo_len;
      r = ($urandom % 8) == 0;
      d = ($urandom % 8) == 0;
      m = ($urandom % 6) != 0;
      hi_len = $urandom_range(1, 70);
      lo_len = $urandom_range(1, 90);
      for (int k = 0; k < hi_len + lo_len; k++) begin
        logic t, c;
        t = (k < hi_len);
        c = t && (($urandom % 12) == 0);
        drive(t, c, r, d, m);
        chk(jabber, m_jab, "R1", "jabber_o vs model (R3 R10)");
        chk(tx_gate, exp_gate(t, m_jab), "R2", "tx_gate_o vs model");
        chk(col, exp_col(c, t, r, d, m, m_ph), "R4", "col_o vs model (R5 R6 R7 R8 R9 R11)");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule